// File: doc/BRIEF.md
# Wrong-Path Event Detector

This block sits beside the execution and resolution stages of an out-of-order core. It watches for behaviour that a correctly predicted program almost never shows: a null dereference, a misaligned access, a store to a read-only page, and similar. When it sees one, it raises a one-cycle hint. The hint tells the core that some older unresolved branch was very likely mispredicted, so recovery can begin before that branch resolves.

Every cycle the block takes up to five reports. One is a memory operation, with its address, access size, page permission, TLB-miss flag and the bounds of the data and code segments. The others are a branch resolution, a return-stack pop, a fetch address and an integer divide. Each report carries the age of its instruction, and a lower age means an older instruction. The block registers the single winning event and presents its code and age one cycle later. What the core does with the hint is outside this block.

Top module: `wp_event_detector`

## Requirements
- R1: A memory operation to address zero raises code 1.
- R2: A store (`mem_write`=1) to a page marked read-only raises code 2. A load from such a page raises nothing.
- R3: A memory access of 2^`mem_size` bytes whose address is not a multiple of that size raises code 3.
- R4: A memory address below `seg_lo` or above `seg_hi` raises code 4.
- R5: A memory address within `code_lo`..`code_hi` inclusive raises code 5.
- R6: A memory operation with `mem_tlb_miss`=1 raises code 6 when the misses already outstanding, plus this one, reach `TLB_LIMIT` (default 2). Each miss adds one to the outstanding count and each `tlb_fill` pulse removes one.
- R7: A branch resolved as mispredicted while `br_older` is nonzero adds one to a counter. When the counter reaches 3, code 7 is raised and the counter returns to zero. A branch resolved with `br_older`=0 also clears the counter.
- R8: A return-stack pop that reports underflow raises code 8. A pop without underflow raises nothing.
- R9: A fetch address with either of its two low bits set raises code 9.
- R10: A divide whose divisor is zero raises code 10.
- R11: When several events occur in one cycle, the event from the lowest age is reported. If ages are equal, the lowest code wins. Events from one memory operation share its age.
- R12: `wpe_valid` pulses for exactly one cycle, one clock after the triggering report. After reset and in cycles with no event it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | Memory report present |
| mem_write | input | 1 | Report is a store |
| mem_addr | input | AW | Effective address |
| mem_size | input | 2 | log2 of access bytes |
| mem_page_ro | input | 1 | Page is read-only |
| mem_tlb_miss | input | 1 | Access missed in the TLB |
| mem_age | input | AGE_W | Age of the memory op |
| tlb_fill | input | 1 | One outstanding TLB miss completed |
| seg_lo | input | AW | Data segment low bound |
| seg_hi | input | AW | Data segment high bound |
| code_lo | input | AW | Code segment low bound |
| code_hi | input | AW | Code segment high bound |
| br_valid | input | 1 | Branch resolution present |
| br_mispredict | input | 1 | Branch resolved as mispredicted |
| br_older | input | CW | Count of older unresolved branches |
| br_age | input | AGE_W | Age of the branch |
| ras_pop | input | 1 | Return stack popped |
| ras_underflow | input | 1 | Pop underflowed |
| ras_age | input | AGE_W | Age of the return |
| fetch_valid | input | 1 | Fetch address present |
| fetch_pc | input | AW | Fetch address |
| fetch_age | input | AGE_W | Age tag of the fetch |
| div_valid | input | 1 | Divide present |
| div_divisor | input | DW | Divisor value |
| div_age | input | AGE_W | Age of the divide |
| wpe_valid | output | 1 | Event pulse |
| wpe_code | output | 4 | Event code, 1 to 10 |
| wpe_age | output | AGE_W | Age of the triggering instruction |

## Verification
The assertions check a set of properties on every cycle. The output code is always legal. A null access, a zero divisor or a misaligned fetch always produces a pulse on the next cycle, with an age no younger than that report. A code 7 pulse is always preceded by a qualifying mispredict. A cycle with no reports is always followed by silence. Some behaviour only the bench scenarios can show: the counting histories behind R6 and R7, including the counter clearing on an idle branch, the negative cases such as loads from read-only pages, and the exact winner when ages tie.

// File: rtl/wp_event_detector.sv
module wp_event_detector #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int AGE_W     = 6,
  parameter int CW        = 4,
  parameter int TLB_LIMIT = 2,
  parameter int TLB_MAX   = 15,
  parameter int MUP_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_valid,
  input  logic             mem_write,
  input  logic [AW-1:0]    mem_addr,
  input  logic [1:0]       mem_size,
  input  logic             mem_page_ro,
  input  logic             mem_tlb_miss,
  input  logic [AGE_W-1:0] mem_age,
  input  logic             tlb_fill,
  input  logic [AW-1:0]    seg_lo,
  input  logic [AW-1:0]    seg_hi,
  input  logic [AW-1:0]    code_lo,
  input  logic [AW-1:0]    code_hi,
  input  logic             br_valid,
  input  logic             br_mispredict,
  input  logic [CW-1:0]    br_older,
  input  logic [AGE_W-1:0] br_age,
  input  logic             ras_pop,
  input  logic             ras_underflow,
  input  logic [AGE_W-1:0] ras_age,
  input  logic             fetch_valid,
  input  logic [AW-1:0]    fetch_pc,
  input  logic [AGE_W-1:0] fetch_age,
  input  logic             div_valid,
  input  logic [DW-1:0]    div_divisor,
  input  logic [AGE_W-1:0] div_age,
  output logic             wpe_valid,
  output logic [3:0]       wpe_code,
  output logic [AGE_W-1:0] wpe_age
);
  localparam int TW  = $clog2(TLB_MAX + 1);
  localparam int MW  = $clog2(MUP_LIMIT + 1);
  localparam int NSRC = 5;

  logic [TW-1:0] tlb_out;
  logic [MW-1:0] mup_cnt;

  logic [AW-1:0] size_mask;
  logic          m_null, m_ro, m_unal, m_seg, m_code, m_tlb;
  logic [3:0]    mem_code;

  assign size_mask = (AW'(1) << mem_size) - AW'(1);
  assign m_null = mem_valid && (mem_addr == '0);
  assign m_ro   = mem_valid && mem_write && mem_page_ro;
  assign m_unal = mem_valid && ((mem_addr & size_mask) != '0);
  assign m_seg  = mem_valid && ((mem_addr < seg_lo) || (mem_addr > seg_hi));
  assign m_code = mem_valid && (mem_addr >= code_lo) && (mem_addr <= code_hi);
  assign m_tlb  = mem_valid && mem_tlb_miss &&
                  ((32'(tlb_out) + 32'd1) >= 32'(TLB_LIMIT));

  always_comb begin
    mem_code = 4'd0;
    if      (m_null) mem_code = 4'd1;
    else if (m_ro)   mem_code = 4'd2;
    else if (m_unal) mem_code = 4'd3;
    else if (m_seg)  mem_code = 4'd4;
    else if (m_code) mem_code = 4'd5;
    else if (m_tlb)  mem_code = 4'd6;
  end

  logic tlb_inc, tlb_dec;
  assign tlb_inc = mem_valid && mem_tlb_miss && (tlb_out != TW'(TLB_MAX));
  assign tlb_dec = tlb_fill && (tlb_out != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                tlb_out <= '0;
    else if (tlb_inc && !tlb_dec) tlb_out <= tlb_out + TW'(1);
    else if (tlb_dec && !tlb_inc) tlb_out <= tlb_out - TW'(1);
  end

  logic mup_hit, mup_step;
  assign mup_step = br_valid && br_mispredict && (br_older != '0);
  assign mup_hit  = mup_step && ((32'(mup_cnt) + 32'd1) >= 32'(MUP_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)                          mup_cnt <= '0;
    else if (br_valid && br_older == '0) mup_cnt <= '0;
    else if (mup_hit)                    mup_cnt <= '0;
    else if (mup_step)                   mup_cnt <= mup_cnt + MW'(1);
  end

  logic [NSRC-1:0] c_v;
  logic [3:0]      c_code [NSRC];
  logic [AGE_W-1:0] c_age [NSRC];

  assign c_v[0] = mem_code != 4'd0;
  assign c_code[0] = mem_code;
  assign c_age[0]  = mem_age;
  assign c_v[1] = mup_hit;
  assign c_code[1] = 4'd7;
  assign c_age[1]  = br_age;
  assign c_v[2] = ras_pop && ras_underflow;
  assign c_code[2] = 4'd8;
  assign c_age[2]  = ras_age;
  assign c_v[3] = fetch_valid && (fetch_pc[1:0] != 2'b00);
  assign c_code[3] = 4'd9;
  assign c_age[3]  = fetch_age;
  assign c_v[4] = div_valid && (div_divisor == '0);
  assign c_code[4] = 4'd10;
  assign c_age[4]  = div_age;

  logic             sel_v;
  logic [3:0]       sel_code;
  logic [AGE_W-1:0] sel_age;

  always_comb begin
    sel_v    = 1'b0;
    sel_code = 4'd0;
    sel_age  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (c_v[i] && (!sel_v || c_age[i] < sel_age ||
                     (c_age[i] == sel_age && c_code[i] < sel_code))) begin
        sel_v    = 1'b1;
        sel_code = c_code[i];
        sel_age  = c_age[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpe_valid <= 1'b0;
      wpe_code  <= 4'd0;
      wpe_age   <= '0;
    end else begin
      wpe_valid <= sel_v;
      wpe_code  <= sel_v ? sel_code : 4'd0;
      wpe_age   <= sel_v ? sel_age : '0;
    end
  end
endmodule

// File: rtl/wp_event_detector_chk.sv
module wp_event_detector_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int AGE_W = 6,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_valid,
  input logic [AW-1:0]    mem_addr,
  input logic [AGE_W-1:0] mem_age,
  input logic             br_valid,
  input logic             br_mispredict,
  input logic [CW-1:0]    br_older,
  input logic             ras_pop,
  input logic             fetch_valid,
  input logic [AW-1:0]    fetch_pc,
  input logic [AGE_W-1:0] fetch_age,
  input logic             div_valid,
  input logic [DW-1:0]    div_divisor,
  input logic [AGE_W-1:0] div_age,
  input logic             wpe_valid,
  input logic [3:0]       wpe_code,
  input logic [AGE_W-1:0] wpe_age
);
  assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wpe_valid |-> (wpe_code >= 4'd1 && wpe_code <= 4'd10));

  assert_null_seen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_addr == '0) |=> (wpe_valid && wpe_age <= $past(mem_age)));

  assert_fetch_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_pc[1:0] != 2'b00) |=> (wpe_valid && wpe_age <= $past(fetch_age)));

  assert_div_seen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_valid && div_divisor == '0) |=> (wpe_valid && wpe_age <= $past(div_age)));

  assert_mup_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wpe_valid && wpe_code == 4'd7) |-> $past(br_valid && br_mispredict && br_older != '0));

  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid || br_valid || ras_pop || fetch_valid || div_valid) |=> !wpe_valid);
endmodule

bind wp_event_detector wp_event_detector_chk #(.AW(AW), .DW(DW), .AGE_W(AGE_W), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_age(mem_age),
  .br_valid(br_valid), .br_mispredict(br_mispredict), .br_older(br_older), .ras_pop(ras_pop),
  .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_age(fetch_age),
  .div_valid(div_valid), .div_divisor(div_divisor), .div_age(div_age),
  .wpe_valid(wpe_valid), .wpe_code(wpe_code), .wpe_age(wpe_age));

// File: tb/wp_event_detector_test.sv
module wp_event_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, AGE_W = 6, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_valid, mem_write, mem_page_ro, mem_tlb_miss, tlb_fill;
  logic [AW-1:0] mem_addr, seg_lo, seg_hi, code_lo, code_hi, fetch_pc;
  logic [1:0] mem_size;
  logic [AGE_W-1:0] mem_age, br_age, ras_age, fetch_age, div_age, wpe_age;
  logic br_valid, br_mispredict, ras_pop, ras_underflow, fetch_valid, div_valid, wpe_valid;
  logic [CW-1:0] br_older;
  logic [DW-1:0] div_divisor;
  logic [3:0] wpe_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_event_detector #(.AW(AW), .DW(DW), .AGE_W(AGE_W), .CW(CW)) uut (.*);

  typedef struct {
    logic v; logic [3:0] code; logic [AGE_W-1:0] age; string req;
  } exp_t;
  exp_t q[$];
  int applied = 0, bad = 0;

  task automatic clr();
    mem_valid = 0; mem_write = 0; mem_addr = 32'h4000; mem_size = 0; mem_page_ro = 0;
    mem_tlb_miss = 0; mem_age = 0; tlb_fill = 0;
    br_valid = 0; br_mispredict = 0; br_older = 0; br_age = 0;
    ras_pop = 0; ras_underflow = 0; ras_age = 0;
    fetch_valid = 0; fetch_pc = 0; fetch_age = 0;
    div_valid = 0; div_divisor = 1; div_age = 0;
  endtask

  task automatic expect_item(logic v, logic [3:0] c, logic [AGE_W-1:0] a, string r);
    exp_t e;
    e.v = v; e.code = c; e.age = a; e.req = r;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      applied++;
      if (wpe_valid !== e.v || (e.v && (wpe_code !== e.code || wpe_age !== e.age))) begin
        bad++;
        $display("FAIL %s: got v=%0b code=%0d age=%0d, expected v=%0b code=%0d age=%0d",
                 e.req, wpe_valid, wpe_code, wpe_age, e.v, e.code, e.age);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    seg_lo = 32'h1000; seg_hi = 32'hFFFF; code_lo = 32'h1000; code_hi = 32'h1FFF;
    clr();
    repeat (3) @(negedge clk);
    applied++;
    if (wpe_valid !== 1'b0) begin bad++; $display("FAIL R12 reset: got %0b expected 0", wpe_valid); end
    rst_n = 1'b1;
    @(negedge clk); clr(); expect_item(0, 0, 0, "R12 idle");
    @(negedge clk); clr(); mem_valid = 1; mem_addr = 0; mem_age = 5; expect_item(1, 1, 5, "R1");
    @(negedge clk); clr(); mem_valid = 1; mem_write = 1; mem_page_ro = 1; mem_size = 2; mem_age = 7; expect_item(1, 2, 7, "R2");
    @(negedge clk); clr(); mem_valid = 1; mem_page_ro = 1; mem_size = 2; expect_item(0, 0, 0, "R2 load");
    @(negedge clk); clr(); mem_valid = 1; mem_addr = 32'h4002; mem_size = 2; mem_age = 9; expect_item(1, 3, 9, "R3");
    @(negedge clk); clr(); mem_valid = 1; mem_addr = 32'h4002; mem_size = 1; expect_item(0, 0, 0, "R3 aligned");
    @(negedge clk); clr(); mem_valid = 1; mem_addr = 32'h20000; mem_age = 4; expect_item(1, 4, 4, "R4");
    @(negedge clk); clr(); mem_valid = 1; mem_addr = 32'h1800; mem_age = 2; expect_item(1, 5, 2, "R5");
    @(negedge clk); clr(); mem_valid = 1; mem_tlb_miss = 1; mem_age = 3; expect_item(0, 0, 0, "R6 first");
    @(negedge clk); clr(); mem_valid = 1; mem_tlb_miss = 1; mem_age = 4; expect_item(1, 6, 4, "R6 second");
    @(negedge clk); clr(); tlb_fill = 1; expect_item(0, 0, 0, "R6 fill");
    @(negedge clk); clr(); tlb_fill = 1; expect_item(0, 0, 0, "R6 fill");
    @(negedge clk); clr(); mem_valid = 1; mem_tlb_miss = 1; expect_item(0, 0, 0, "R6 drained");
    @(negedge clk); clr(); tlb_fill = 1; expect_item(0, 0, 0, "R6 fill");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); clr(); br_valid = 1; br_mispredict = 1; br_older = 2; br_age = AGE_W'(10 + k);
      if (k == 2) expect_item(1, 7, 12, "R7 third"); else expect_item(0, 0, 0, "R7 count");
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); clr(); br_valid = 1; br_mispredict = 1; br_older = 1; br_age = 20;
      expect_item(0, 0, 0, "R7 after fire");
    end
    @(negedge clk); clr(); br_valid = 1; br_older = 0; expect_item(0, 0, 0, "R7 clear");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); clr(); br_valid = 1; br_mispredict = 1; br_older = 3; br_age = 30;
      if (k == 2) expect_item(1, 7, 30, "R7 after clear"); else expect_item(0, 0, 0, "R7 after clear");
    end
    @(negedge clk); clr(); ras_pop = 1; ras_underflow = 1; ras_age = 9; expect_item(1, 8, 9, "R8");
    @(negedge clk); clr(); ras_pop = 1; expect_item(0, 0, 0, "R8 normal pop");
    @(negedge clk); clr(); fetch_valid = 1; fetch_pc = 32'h102; fetch_age = 20; expect_item(1, 9, 20, "R9");
    @(negedge clk); clr(); fetch_valid = 1; fetch_pc = 32'h104; expect_item(0, 0, 0, "R9 aligned");
    @(negedge clk); clr(); div_valid = 1; div_divisor = 0; div_age = 11; expect_item(1, 10, 11, "R10");
    @(negedge clk); clr(); div_valid = 1; div_divisor = 5; expect_item(0, 0, 0, "R10 nonzero");
    @(negedge clk); clr(); fetch_valid = 1; fetch_pc = 32'h3; fetch_age = 20;
      div_valid = 1; div_divisor = 0; div_age = 8; expect_item(1, 10, 8, "R11 oldest");
    @(negedge clk); clr(); ras_pop = 1; ras_underflow = 1; ras_age = 6;
      div_valid = 1; div_divisor = 0; div_age = 6; expect_item(1, 8, 6, "R11 tie");
    @(negedge clk); clr(); mem_valid = 1; mem_write = 1; mem_page_ro = 1; mem_age = 6;
      fetch_valid = 1; fetch_pc = 32'h1; fetch_age = 6; expect_item(1, 2, 6, "R11 tie mem");
    @(negedge clk); clr(); mem_valid = 1; mem_addr = 32'h20001; mem_size = 1; mem_age = 5; expect_item(1, 3, 5, "R11 mem order");
    @(negedge clk); clr(); expect_item(0, 0, 0, "R12 pulse ends");
    @(negedge clk); clr();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule